// File: doc/BRIEF.md
# Error-Correcting Local Word Memory Controller

This block owns a small single-cycle RAM of data words and stores every word together with a set of check bits. The check bits let one flipped bit be repaired and two flipped bits be reported. A CPU-side requester issues reads, full-word writes and byte-masked writes through one request port. Read results return on a result port one cycle after the request is accepted. The controller hands back the raw stored data at once, without waiting for the check. When the check finds a repairable fault, the controller tells the requester to replay the access. In the same cycle it writes the repaired word back into the RAM.

The repaired word is also kept, with its address, in a one-entry bypass register. Any later read of that address is answered from the bypass register and not from the RAM. A location with a permanent stuck bit therefore returns correct data on the replay, and the read does not loop forever. A byte-masked write becomes a two-cycle read-merge-write. In the first cycle the old word is read. In the second cycle the merged word is re-encoded and stored, and the request port is not ready. Two-bit faults raise a sticky flag and record the address of the latest such fault.

Top module: `tcm_ecc_top`

## Requirements
- R1: A full-word write followed by a read of the same address returns the written word with rdValid high in the cycle after the read is accepted, and with rdReplay and rdUncorr low. rdValid is low in the cycle after a write.
- R2: Each stored word holds data in bits DATA_W-1:0 and check bits above them. The check bits are six position-weighted parity bits and then one overall parity bit. If any single stored bit (data or check) is flipped, a read returns the raw stored data with rdReplay high, and reqReady is low in that same cycle.
- R3: After a replayed read, the RAM location holds the repaired word. Once the bypass register holds another address, a read of the first address returns clean data with no replay.
- R4: After a replay, reads of that address are served from the bypass register with correct data and no replay or error flag, even if the RAM copy is corrupted again.
- R5: A read that finds two flipped bits returns the raw data with rdUncorr high and rdReplay low. uncorrSticky becomes and stays high, and uncorrAddr shows that address. Neither the RAM nor the bypass register is changed.
- R6: A byte-masked write (reqBe not all ones; lane i covers data bits 8i+7:8i) replaces only the enabled lanes. reqReady is low in the cycle after its acceptance.
- R7: A request presented while reqReady is low is not accepted. It is taken on the first cycle with reqReady high, and its result appears one cycle later.
- R8: A full-word write to the address held in the bypass register invalidates the entry, so the next read of that address comes from the RAM.
- R9: A byte-masked write to the address held in the bypass register merges into the bypass word and updates it, so later reads return the merged word even if the RAM copy is bad.
- R10: A byte-masked write to a location with one flipped bit merges into the repaired word and stores a clean encoding.
- R11: A byte-masked write to a location with two flipped bits is dropped, and it sets uncorrSticky and uncorrAddr.
- R12: After reset, reqReady is high and rdValid, rdReplay, rdUncorr and uncorrSticky are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqBe | input | DATA_W/8 | Byte lane enables for writes |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Request is accepted this cycle when high |
| rdValid | output | 1 | Read result present |
| rdData | output | DATA_W | Read data (raw, or from bypass register) |
| rdReplay | output | 1 | Repairable fault: re-issue the read |
| rdUncorr | output | 1 | Unrepairable fault on this read |
| uncorrSticky | output | 1 | An unrepairable fault has been seen since reset |
| uncorrAddr | output | ADDR_W | Address of the latest unrepairable fault |

## Verification
The bench builds the block with DATA_W = 32 and ADDR_W = 5. The 32-bit word gives the full 39-bit stored code, so the bench flips each of the 39 positions in turn, including every check bit and the overall parity bit, and expects a replay each time. The shallow 32-word array keeps the scenarios on a handful of addresses. It also makes it easy to steer the bypass register between addresses to observe the write-back, the invalidation and the merge into the bypass word.

// File: rtl/tcm_ecc_pkg.sv
package tcm_ecc_pkg;

  // number of position-weighted parity bits needed to cover dataW bits
  function automatic int hamBits(input int dataW);
    int h;
    h = 1;
    while ((1 << h) < dataW + h + 1) h++;
    return h;
  endfunction

  // code position (1-based) of data bit idx; powers of two are parity slots
  function automatic int dataPos(input int idx);
    int p;
    int c;
    p = 0;
    c = -1;
    while (c < idx) begin
      p++;
      if ((p & (p - 1)) != 0) c++;
    end
    return p;
  endfunction

  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_READ = 2'd1,
    ST_RMW  = 2'd2
  } stage_e;

  typedef struct packed {
    logic capture;    // latch request into stage registers
    logic ramRead;    // RAM read this cycle
    logic wrCpu;      // RAM write of encoded request data
    logic wrStage;    // RAM write of merged / repaired stage word
    logic mergeEn;    // apply stage byte enables to the base word
    logic bypLoad;    // fill bypass register with repaired word
    logic bypInvChk;  // full write: drop bypass entry on address match
    logic bypUpd;     // merged word replaces bypass data
    logic stickySet;  // record an unrepairable fault
  } strobe_t;

endpackage

// File: rtl/tcm_secded_enc.sv
module tcm_secded_enc #(
  parameter int DATA_W = 32,
  localparam int HAM_W = tcm_ecc_pkg::hamBits(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);

  function automatic logic [DATA_W-1:0] coverMask(input int k);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) begin
      m[i] = ((tcm_ecc_pkg::dataPos(i) >> k) & 1) == 1;
    end
    return m;
  endfunction

  for (genvar k = 0; k < HAM_W; k++) begin : g_par
    localparam logic [DATA_W-1:0] COVER = coverMask(k);
    assign chk[k] = ^(data & COVER);
  end

  assign chk[HAM_W] = (^data) ^ (^chk[HAM_W-1:0]);

endmodule

// File: rtl/tcm_secded_dec.sv
module tcm_secded_dec #(
  parameter int DATA_W = 32,
  localparam int HAM_W = tcm_ecc_pkg::hamBits(DATA_W),
  localparam int CHK_W = HAM_W + 1,
  localparam int NPOS  = DATA_W + HAM_W
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  chk,
  output logic [DATA_W-1:0] corrData,
  output logic              errSingle,
  output logic              errDouble
);

  logic [CHK_W-1:0] reChk;
  logic [HAM_W-1:0] syn;
  logic             parityOdd;

  tcm_secded_enc #(.DATA_W(DATA_W)) encI (.data(data), .chk(reChk));

  assign syn       = chk[HAM_W-1:0] ^ reChk[HAM_W-1:0];
  assign parityOdd = ^{data, chk};

  assign errSingle = parityOdd && (int'(syn) <= NPOS);
  assign errDouble = (!parityOdd && (syn != '0)) || (parityOdd && (int'(syn) > NPOS));

  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    localparam int POS = tcm_ecc_pkg::dataPos(i);
    assign corrData[i] = data[i] ^ (parityOdd && (int'(syn) == POS));
  end

endmodule

// File: rtl/tcm_ecc_ctrl.sv
module tcm_ecc_ctrl #(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [NB-1:0]          reqBe,
  input  logic                   errSingle,
  input  logic                   errDouble,
  input  logic                   stBypHit,
  output tcm_ecc_pkg::strobe_t   strb,
  output logic                   reqReady,
  output logic                   rdValid,
  output logic                   rdReplay,
  output logic                   rdUncorr
);
  import tcm_ecc_pkg::*;

  stage_e stKind;
  logic   accept;
  logic   fullWr;
  logic   ramFault1;
  logic   ramFault2;
  logic   fixCycle;

  // fault flags only matter when the stage word came from the RAM
  assign ramFault1 = errSingle && !stBypHit;
  assign ramFault2 = errDouble && !stBypHit;
  assign fixCycle  = (stKind == ST_READ) && ramFault1;

  assign reqReady = !((stKind == ST_RMW) || fixCycle);
  assign accept   = reqValid && reqReady;
  assign fullWr   = reqWrite && (&reqBe);

  always_comb begin
    strb           = '0;
    strb.capture   = accept;
    strb.ramRead   = accept && !fullWr;
    strb.wrCpu     = accept && fullWr;
    strb.bypInvChk = accept && fullWr;
    strb.mergeEn   = (stKind == ST_RMW);
    strb.wrStage   = fixCycle || ((stKind == ST_RMW) && !ramFault2);
    strb.bypLoad   = fixCycle;
    strb.bypUpd    = (stKind == ST_RMW) && stBypHit;
    strb.stickySet = (stKind != ST_NONE) && ramFault2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stKind <= ST_NONE;
    end else if (accept && !reqWrite) begin
      stKind <= ST_READ;
    end else if (accept && !fullWr) begin
      stKind <= ST_RMW;
    end else begin
      stKind <= ST_NONE;
    end
  end

  assign rdValid  = (stKind == ST_READ);
  assign rdReplay = fixCycle;
  assign rdUncorr = (stKind == ST_READ) && ramFault2;

  p_read_result_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> rdValid);

  p_replay_blocks_port_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdReplay |-> !reqReady);

  p_replay_writes_back_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdReplay |-> (strb.wrStage && !strb.wrCpu && !strb.ramRead));

  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReplay && rdUncorr));

  p_uncorr_no_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdUncorr |-> !strb.wrStage);

  p_masked_write_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && !(&reqBe)) |=> !reqReady);

endmodule

// File: rtl/tcm_ecc_datapath.sv
module tcm_ecc_datapath #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  localparam int HAM_W = tcm_ecc_pkg::hamBits(DATA_W),
  localparam int CHK_W = HAM_W + 1,
  localparam int CW    = DATA_W + CHK_W,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int NB    = DATA_W / 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tcm_ecc_pkg::strobe_t strb,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [NB-1:0]        reqBe,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 errSingle,
  output logic                 errDouble,
  output logic                 stBypHit,
  output logic [DATA_W-1:0]    rdData,
  output logic                 uncorrSticky,
  output logic [ADDR_W-1:0]    uncorrAddr
);

  logic [CW-1:0]     memArray [DEPTH];
  logic [CW-1:0]     ramQ;
  logic [ADDR_W-1:0] ramAddr;
  logic [CW-1:0]     ramWd;
  logic              ramWe;

  logic [ADDR_W-1:0] stAddr;
  logic [NB-1:0]     stBe;
  logic [DATA_W-1:0] stWdata;

  logic              bypValid;
  logic [ADDR_W-1:0] bypAddr;
  logic [DATA_W-1:0] bypData;

  logic [DATA_W-1:0] corrWord;
  logic [DATA_W-1:0] baseWord;
  logic [DATA_W-1:0] mergedWord;
  logic [CHK_W-1:0]  cpuChk;
  logic [CHK_W-1:0]  mergeChk;

  // ---------------- RAM ----------------
  assign ramAddr = strb.wrStage ? stAddr : reqAddr;
  assign ramWd   = strb.wrStage ? {mergeChk, mergedWord} : {cpuChk, reqWdata};
  assign ramWe   = strb.wrCpu || strb.wrStage;

  always_ff @(posedge clk) begin
    if (ramWe) memArray[ramAddr] <= ramWd;
    if (strb.ramRead) ramQ <= memArray[ramAddr];
  end

  // ---------------- stage registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stAddr  <= '0;
      stBe    <= '0;
      stWdata <= '0;
    end else if (strb.capture) begin
      stAddr  <= reqAddr;
      stBe    <= reqBe;
      stWdata <= reqWdata;
    end
  end

  // ---------------- check / repair ----------------
  tcm_secded_dec #(.DATA_W(DATA_W)) decI (
    .data     (ramQ[DATA_W-1:0]),
    .chk      (ramQ[CW-1:DATA_W]),
    .corrData (corrWord),
    .errSingle(errSingle),
    .errDouble(errDouble)
  );

  tcm_secded_enc #(.DATA_W(DATA_W)) cpuEncI   (.data(reqWdata),   .chk(cpuChk));
  tcm_secded_enc #(.DATA_W(DATA_W)) mergeEncI (.data(mergedWord), .chk(mergeChk));

  assign stBypHit = bypValid && (bypAddr == stAddr);
  assign baseWord = stBypHit ? bypData : corrWord;
  assign rdData   = stBypHit ? bypData : ramQ[DATA_W-1:0];

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign mergedWord[8*b +: 8] = (strb.mergeEn && stBe[b]) ? stWdata[8*b +: 8]
                                                             : baseWord[8*b +: 8];
  end

  // ---------------- bypass register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bypValid <= 1'b0;
      bypAddr  <= '0;
      bypData  <= '0;
    end else if (strb.bypLoad) begin
      bypValid <= 1'b1;
      bypAddr  <= stAddr;
      bypData  <= corrWord;
    end else if (strb.bypUpd) begin
      bypData  <= mergedWord;
    end else if (strb.bypInvChk && (reqAddr == bypAddr)) begin
      bypValid <= 1'b0;
    end
  end

  // ---------------- unrepairable fault log ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uncorrSticky <= 1'b0;
      uncorrAddr   <= '0;
    end else if (strb.stickySet) begin
      uncorrSticky <= 1'b1;
      uncorrAddr   <= stAddr;
    end
  end

  p_bypass_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.bypLoad |=> (bypValid && (bypAddr == $past(stAddr))));

  p_sticky_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    uncorrSticky |=> uncorrSticky);

  p_full_write_drops_entry_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bypInvChk && bypValid && (reqAddr == bypAddr)) |=> !bypValid);

  p_merge_tracks_bypass_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.bypUpd |=> (bypValid && (bypData == $past(mergedWord))));

endmodule

// File: rtl/tcm_ecc_top.sv
module tcm_ecc_top #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  localparam int NB = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [NB-1:0]     reqBe,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdReplay,
  output logic              rdUncorr,
  output logic              uncorrSticky,
  output logic [ADDR_W-1:0] uncorrAddr
);

  tcm_ecc_pkg::strobe_t strb;
  logic errSingle;
  logic errDouble;
  logic stBypHit;

  tcm_ecc_ctrl #(.DATA_W(DATA_W)) ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqBe    (reqBe),
    .errSingle(errSingle),
    .errDouble(errDouble),
    .stBypHit (stBypHit),
    .strb     (strb),
    .reqReady (reqReady),
    .rdValid  (rdValid),
    .rdReplay (rdReplay),
    .rdUncorr (rdUncorr)
  );

  tcm_ecc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpI (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqAddr     (reqAddr),
    .reqBe       (reqBe),
    .reqWdata    (reqWdata),
    .errSingle   (errSingle),
    .errDouble   (errDouble),
    .stBypHit    (stBypHit),
    .rdData      (rdData),
    .uncorrSticky(uncorrSticky),
    .uncorrAddr  (uncorrAddr)
  );

endmodule

// File: tb/tcm_ecc_top_tb_top.sv
module tcm_ecc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int CWB = 39;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [3:0]    reqBe = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqReady;
  logic          rdValid;
  logic [DW-1:0] rdData;
  logic          rdReplay;
  logic          rdUncorr;
  logic          uncorrSticky;
  logic [AW-1:0] uncorrAddr;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcm_ecc_top #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata), .reqReady(reqReady),
    .rdValid(rdValid), .rdData(rdData), .rdReplay(rdReplay), .rdUncorr(rdUncorr),
    .uncorrSticky(uncorrSticky), .uncorrAddr(uncorrAddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitReady();
    @(negedge clk);
    while (!reqReady) @(negedge clk);
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [DW-1:0] d,
                        output logic rep, output logic unc, output logic vld, output logic rdy);
    waitReady();
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqBe = 4'hF;
    @(negedge clk);
    reqValid = 1'b0;
    d = rdData; rep = rdReplay; unc = rdUncorr; vld = rdValid; rdy = reqReady;
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    waitReady();
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqBe = 4'hF; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doPartial(input logic [AW-1:0] a, input logic [3:0] be,
                           input logic [DW-1:0] d, output logic rdy);
    waitReady();
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqBe = be; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    rdy = reqReady;
  endtask

  task automatic corrupt(input logic [AW-1:0] a, input logic [CWB-1:0] mask);
    @(negedge clk);
    dut_i.dpI.memArray[a] = dut_i.dpI.memArray[a] ^ mask;
  endtask

  // checks a read result against expected data and flags
  task automatic expectRead(input logic [AW-1:0] a, input logic [DW-1:0] expD,
                            input logic expRep, input logic expUnc, input string tag);
    logic [DW-1:0] d;
    logic rep, unc, vld, rdy;
    doRead(a, d, rep, unc, vld, rdy);
    chk(vld == 1'b1, {tag, " rdValid"}, 64'(vld), 64'd1);
    chk(d == expD, {tag, " rdData"}, 64'(d), 64'(expD));
    chk(rep == expRep, {tag, " rdReplay"}, 64'(rep), 64'(expRep));
    chk(unc == expUnc, {tag, " rdUncorr"}, 64'(unc), 64'(expUnc));
    if (expRep) chk(rdy == 1'b0, {tag, " reqReady during replay"}, 64'(rdy), 64'd0);
  endtask

  task automatic testReset();
    chk(reqReady == 1'b1, "R12 reqReady", 64'(reqReady), 64'd1);
    chk(rdValid == 1'b0, "R12 rdValid", 64'(rdValid), 64'd0);
    chk(rdReplay == 1'b0, "R12 rdReplay", 64'(rdReplay), 64'd0);
    chk(rdUncorr == 1'b0, "R12 rdUncorr", 64'(rdUncorr), 64'd0);
    chk(uncorrSticky == 1'b0, "R12 uncorrSticky", 64'(uncorrSticky), 64'd0);
  endtask

  task automatic testCleanAccess();
    doWrite(5'd0, 32'hDEAD_BEEF);
    chk(rdValid == 1'b0, "R1 no result after write", 64'(rdValid), 64'd0);
    expectRead(5'd0, 32'hDEAD_BEEF, 1'b0, 1'b0, "R1 clean read");
    doWrite(5'd31, 32'h0000_0001);
    expectRead(5'd31, 32'h0000_0001, 1'b0, 1'b0, "R1 top address");
  endtask

  task automatic testSingleFlips();
    for (int b = 0; b < CWB; b++) begin
      logic [DW-1:0] base;
      logic [DW-1:0] raw;
      base = 32'h8421_5A3C ^ DW'(b * 32'h0101_0101);
      raw  = (b < DW) ? (base ^ (32'h1 << b)) : base;
      doWrite(5'd1, base);
      corrupt(5'd1, CWB'(1) << b);
      expectRead(5'd1, raw, 1'b1, 1'b0, $sformatf("R2 flip bit %0d", b));
      expectRead(5'd1, base, 1'b0, 1'b0, $sformatf("R4 bypass after flip %0d", b));
    end
  endtask

  task automatic testWriteBack();
    doWrite(5'd2, 32'h1357_9BDF);
    corrupt(5'd2, CWB'(1) << 5);
    expectRead(5'd2, 32'h1357_9BDF ^ 32'h20, 1'b1, 1'b0, "R2 addr2 replay");
    doWrite(5'd3, 32'h2468_ACE0);
    corrupt(5'd3, CWB'(1) << 10);
    expectRead(5'd3, 32'h2468_ACE0 ^ 32'h400, 1'b1, 1'b0, "R2 addr3 replay");
    expectRead(5'd2, 32'h1357_9BDF, 1'b0, 1'b0, "R3 repaired copy in RAM");
  endtask

  task automatic testHardFault();
    corrupt(5'd3, CWB'(1) << 10);
    expectRead(5'd3, 32'h2468_ACE0, 1'b0, 1'b0, "R4 stuck bit served by bypass");
    expectRead(5'd3, 32'h2468_ACE0, 1'b0, 1'b0, "R4 repeated re-read");
  endtask

  task automatic testDouble();
    doWrite(5'd4, 32'hA5A5_0F0F);
    corrupt(5'd4, CWB'(39'h81));
    expectRead(5'd4, 32'hA5A5_0F0F ^ 32'h81, 1'b0, 1'b1, "R5 double fault read");
    @(negedge clk);
    chk(uncorrSticky == 1'b1, "R5 sticky set", 64'(uncorrSticky), 64'd1);
    chk(uncorrAddr == 5'd4, "R5 logged address", 64'(uncorrAddr), 64'd4);
    expectRead(5'd4, 32'hA5A5_0F0F ^ 32'h81, 1'b0, 1'b1, "R5 no write-back");
    expectRead(5'd3, 32'h2468_ACE0, 1'b0, 1'b0, "R5 bypass untouched");
    chk(uncorrSticky == 1'b1, "R5 sticky held", 64'(uncorrSticky), 64'd1);
  endtask

  task automatic testPartial();
    logic rdy;
    doWrite(5'd5, 32'h1122_3344);
    doPartial(5'd5, 4'b0101, 32'hAABB_CCDD, rdy);
    chk(rdy == 1'b0, "R6 ready low in merge cycle", 64'(rdy), 64'd0);
    expectRead(5'd5, 32'h11BB_33DD, 1'b0, 1'b0, "R6 merged lanes");
  endtask

  task automatic testStall();
    doWrite(5'd6, 32'hCAFE_F00D);
    waitReady();
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 5'd6; reqBe = 4'b1000; reqWdata = 32'h5A00_0000;
    @(negedge clk);
    reqWrite = 1'b0; reqBe = 4'hF;
    chk(reqReady == 1'b0, "R7 port busy", 64'(reqReady), 64'd0);
    @(negedge clk);
    chk(rdValid == 1'b0, "R7 stalled read not returned", 64'(rdValid), 64'd0);
    chk(reqReady == 1'b1, "R7 port free again", 64'(reqReady), 64'd1);
    @(negedge clk);
    reqValid = 1'b0;
    chk(rdValid == 1'b1, "R7 held read returns", 64'(rdValid), 64'd1);
    chk(rdData == 32'h5AFE_F00D, "R7 held read sees merge", 64'(rdData), 64'h5AFE_F00D);
  endtask

  task automatic testBypassMerge();
    logic rdy;
    doPartial(5'd3, 4'b0001, 32'h0000_00EE, rdy);
    chk(rdy == 1'b0, "R9 ready low", 64'(rdy), 64'd0);
    corrupt(5'd3, CWB'(39'h6));
    expectRead(5'd3, 32'h2468_ACEE, 1'b0, 1'b0, "R9 merged bypass word");
  endtask

  task automatic testFullInvalidate();
    doWrite(5'd3, 32'h7777_1234);
    expectRead(5'd3, 32'h7777_1234, 1'b0, 1'b0, "R8 entry dropped");
  endtask

  task automatic testRmwRepair();
    logic rdy;
    doWrite(5'd7, 32'h0102_0304);
    corrupt(5'd7, CWB'(1) << 20);
    doPartial(5'd7, 4'b0001, 32'h0000_00FF, rdy);
    chk(rdy == 1'b0, "R10 ready low", 64'(rdy), 64'd0);
    expectRead(5'd7, 32'h0102_03FF, 1'b0, 1'b0, "R10 merge onto repaired word");
  endtask

  task automatic testRmwDouble();
    logic rdy;
    doWrite(5'd8, 32'h0F0F_0F0F);
    corrupt(5'd8, CWB'(39'h18));
    doPartial(5'd8, 4'b0010, 32'h0000_AA00, rdy);
    @(negedge clk);
    chk(uncorrAddr == 5'd8, "R11 logged address", 64'(uncorrAddr), 64'd8);
    chk(uncorrSticky == 1'b1, "R11 sticky", 64'(uncorrSticky), 64'd1);
    expectRead(5'd8, 32'h0F0F_0F17, 1'b0, 1'b1, "R11 write dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCleanAccess();
    testSingleFlips();
    testWriteBack();
    testHardFault();
    testDouble();
    testPartial();
    testStall();
    testBypassMerge();
    testFullInvalidate();
    testRmwRepair();
    testRmwDouble();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule